// File: doc/BRIEF.md
# Byte-Serial Stream Port with Request Handshake

This block is the device end of a byte-oriented synchronous serial link. The host owns the serial clock. It uses that clock to push a compressed data stream into the device, or to pull encoded data back out. The device never drives the clock. It paces the host through one request output, which the host polls between bytes and obeys before it starts the next byte.

Inside the block the serial clock and data pass through a two-flop synchroniser into the system clock, and falling edges are detected there. The system clock must run at least four times faster than the serial clock. In receive mode each detected falling edge samples one data bit into a shift register. Every eighth bit pushes a completed byte into a receive FIFO, which the core drains through a valid/ready pair. In transmit mode the core loads bytes into a transmit FIFO through a valid/ready pair. On each falling edge the block presents the next bit, and holds it until the following falling edge so that the host can sample on the rising edge.

Bit order is MSB-first after reset and can be changed at run time with two pulse inputs. A direction input selects receive or transmit. Changing it discards any partially shifted byte.

Top module: `byte_serial_port`

## Requirements
- R1: While reset is high, xfer_req, rx_valid, sd_out and sd_out_en are 0, tx_ready is 1, both FIFOs are empty, the direction is receive and the bit order is MSB-first.
- R2: In receive mode with MSB-first order, the bit sampled at the first falling serial clock edge of a byte lands in bit 7 of the received byte, and the last one lands in bit 0.
- R3: A pulse on order_lsb_set selects LSB-first order, where the first bit lands in bit 0. A pulse on order_msb_set restores MSB-first. If both pulse in the same cycle, MSB-first is selected.
- R4: Every serial word is exactly 8 bits. After the eighth falling edge the byte enters the receive FIFO. rx_valid then stays high with the oldest byte on rx_data until a cycle with rx_ready high removes it.
- R5: In receive mode xfer_req is high exactly when the receive FIFO holds fewer than FIFO_DEPTH bytes, one cycle behind the FIFO level. A byte that completes while the FIFO is full is dropped.
- R6: tx_ready is high whenever the transmit FIFO is not full. A byte offered with tx_valid high in such a cycle is queued.
- R7: In transmit mode sd_out changes only after a detected falling edge. The first falling edge of a byte loads the oldest queued byte and presents its first bit, in the current bit order. If the FIFO is empty at that edge, sd_out holds its value.
- R8: In transmit mode xfer_req is high exactly when the transmit FIFO holds at least one byte, one cycle behind the FIFO level.
- R9: Any change of mode_tx clears the bit counter, so a partly received byte is discarded and the next byte starts at bit position zero.
- R10: The bit order in effect at the first bit of a byte governs the whole byte. A change made mid-byte takes effect from the next byte.
- R11: sd_out_en is high in transmit mode and low in receive mode, one cycle behind mode_tx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_in | input | 1 | Serial clock from the host |
| sd_in | input | 1 | Serial data from the host |
| sd_out | output | 1 | Serial data to the host |
| sd_out_en | output | 1 | Output enable for sd_out (transmit mode) |
| xfer_req | output | 1 | Request: host may transfer a byte |
| mode_tx | input | 1 | 0 = receive, 1 = transmit |
| order_lsb_set | input | 1 | Pulse: select LSB-first order |
| order_msb_set | input | 1 | Pulse: select MSB-first order |
| rx_data | output | WORD_BITS | Oldest received byte |
| rx_valid | output | 1 | Receive FIFO not empty |
| rx_ready | input | 1 | Core consumes rx_data |
| tx_data | input | WORD_BITS | Byte to send |
| tx_valid | input | 1 | tx_data offered |
| tx_ready | output | 1 | Transmit FIFO has room |

## Verification
A wrong bit counter or a stale bit-order latch gives a rotated or mirrored byte on rx_data within one serial byte time, or a wrong bit on sd_out at the very next falling edge. A wrong FIFO level shows on xfer_req one cycle later, and on rx_valid or tx_ready at once. The bench models the synchroniser delay, the FIFOs and the shift state behaviourally and compares every output on every clock. It also checks each byte as the host would assemble it.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  parameter int unsigned WORD_BITS = 8;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;
endpackage

// File: rtl/bsp_sync.sv
module bsp_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_raw,
  input  logic sd_raw,
  output logic sck_fall,
  output logic sd_synced
);
  logic [STAGES-1:0] ck_pipe;
  logic [STAGES-1:0] dt_pipe;
  logic              ck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_pipe <= '0;
      dt_pipe <= '0;
      ck_prev <= 1'b0;
    end else begin
      ck_pipe <= {ck_pipe[STAGES-2:0], sck_raw};
      dt_pipe <= {dt_pipe[STAGES-2:0], sd_raw};
      ck_prev <= ck_pipe[STAGES-1];
    end
  end

  assign sck_fall  = ck_prev & ~ck_pipe[STAGES-1];
  assign sd_synced = dt_pipe[STAGES-1];
endmodule

// File: rtl/bsp_fifo.sv
module bsp_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    store [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            wr_en, rd_en;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign wr_en = push & ~full;
  assign rd_en = pop & ~empty;
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (rd_en) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CNTW'(1);
        2'b01:   count <= count - CNTW'(1);
        default: count <= count;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> $stable(count));

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/bsp_engine.sv
module bsp_engine #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_tx,
  input  logic         fall,
  input  logic         bit_in,
  input  logic         order_lsb,
  input  logic         tx_empty,
  input  logic [W-1:0] tx_head,
  output logic         tx_pop,
  output logic         rx_push,
  output logic [W-1:0] rx_byte,
  output logic         sd_out,
  output logic         dir_q
);
  localparam int unsigned CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic          byte_lsb;
  logic [W-1:0]  rx_sh, tx_sh;
  logic          chg, first, last, lsb_now, out_bit, tx_step;
  logic [W-1:0]  rx_next, tx_src, tx_next;

  assign chg     = (mode_tx != dir_q);
  assign first   = (cnt == '0);
  assign last    = (cnt == CW'(W - 1));
  assign lsb_now = first ? order_lsb : byte_lsb;
  assign rx_next = lsb_now ? {bit_in, rx_sh[W-1:1]} : {rx_sh[W-2:0], bit_in};
  assign tx_src  = first ? tx_head : tx_sh;
  assign out_bit = lsb_now ? tx_src[0] : tx_src[W-1];
  assign tx_next = lsb_now ? {1'b0, tx_src[W-1:1]} : {tx_src[W-2:0], 1'b0};
  assign tx_step = !chg && fall && mode_tx && (!first || !tx_empty);

  assign rx_push = !chg && fall && !mode_tx && last;
  assign rx_byte = rx_next;
  assign tx_pop  = tx_step && first;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= 1'b0;
      cnt      <= '0;
      byte_lsb <= 1'b0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      sd_out   <= 1'b0;
    end else begin
      dir_q <= mode_tx;
      if (chg) begin
        cnt <= '0;
      end else if (fall && !mode_tx) begin
        rx_sh    <= rx_next;
        byte_lsb <= lsb_now;
        cnt      <= last ? '0 : cnt + CW'(1);
      end else if (tx_step) begin
        tx_sh    <= tx_next;
        sd_out   <= out_bit;
        byte_lsb <= lsb_now;
        cnt      <= last ? '0 : cnt + CW'(1);
      end
    end
  end

  // R9
  dir_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_tx != dir_q) |=> (cnt == '0));

  // R7
  out_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_out) |-> $past(fall && mode_tx));
endmodule

// File: rtl/byte_serial_port.sv
module byte_serial_port
  import bsp_pkg::*;
#(
  parameter int unsigned WORD_W      = WORD_BITS,
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_in,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_out_en,
  output logic              xfer_req,
  input  logic              mode_tx,
  input  logic              order_lsb_set,
  input  logic              order_msb_set,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready
);
  logic              fall, bit_s, order_lsb, dir_q;
  logic              rx_push, rx_full, rx_empty;
  logic              tx_pop, tx_full, tx_empty;
  logic [WORD_W-1:0] rx_byte, tx_head;

  bsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_raw(sck_in), .sd_raw(sd_in),
    .sck_fall(fall), .sd_synced(bit_s)
  );

  bsp_engine #(.W(WORD_W)) u_eng (
    .clk(clk), .rst(rst), .mode_tx(mode_tx), .fall(fall), .bit_in(bit_s),
    .order_lsb(order_lsb), .tx_empty(tx_empty), .tx_head(tx_head),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .sd_out(sd_out), .dir_q(dir_q)
  );

  bsp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
    .pop(rx_ready), .dout(rx_data), .full(rx_full), .empty(rx_empty)
  );

  bsp_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_valid), .din(tx_data),
    .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      order_lsb <= 1'b0;
      xfer_req  <= 1'b0;
    end else begin
      if (order_msb_set)      order_lsb <= 1'b0;
      else if (order_lsb_set) order_lsb <= 1'b1;
      xfer_req <= (dir_q == DIR_TX) ? !tx_empty : !rx_full;
    end
  end

  assign sd_out_en = dir_q;
  assign rx_valid  = !rx_empty;
  assign tx_ready  = !tx_full;

  // R5
  rx_req_full_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_q && rx_full) |=> !xfer_req);

  // R8
  tx_req_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_q && tx_empty) |=> !xfer_req);
endmodule

// File: tb/byte_serial_port_test.sv
module byte_serial_port_test;
  localparam int DEPTH = 4;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck_in = 1'b1, sd_in = 1'b0, mode_tx = 1'b0;
  logic order_lsb_set = 1'b0, order_msb_set = 1'b0;
  logic rx_ready = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic sd_out, sd_out_en, xfer_req, rx_valid, tx_ready;
  logic [7:0] rx_data;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  byte_serial_port #(.WORD_W(8), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .sck_in(sck_in), .sd_in(sd_in), .sd_out(sd_out),
    .sd_out_en(sd_out_en), .xfer_req(xfer_req), .mode_tx(mode_tx),
    .order_lsb_set(order_lsb_set), .order_msb_set(order_msb_set),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int ms1, ms2, ms3, md1, md2;
  int mdir, mlsb, mcnt, mblsb, mreq, mout;
  int fall_e, bin, chg, lsbn, rxs, txs, rxpush, txpop;
  logic [7:0] acc, mtxb;
  logic [7:0] rxq[$];
  logic [7:0] txq[$];

  always @(posedge clk) begin
    if (rst) begin
      ms1 = 0; ms2 = 0; ms3 = 0; md1 = 0; md2 = 0;
      mdir = 0; mlsb = 0; mcnt = 0; mblsb = 0; mreq = 0; mout = 0;
      acc = 0; mtxb = 0;
      rxq.delete(); txq.delete();
    end else begin
      fall_e = (ms3 == 1 && ms2 == 0) ? 1 : 0;
      bin = md2;
      rxs = rxq.size(); txs = txq.size();
      mreq = mdir ? (txs != 0) : (rxs != DEPTH);
      chg = (int'(mode_tx) != mdir) ? 1 : 0;
      lsbn = (mcnt == 0) ? mlsb : mblsb;
      rxpush = 0; txpop = 0;
      if (chg) mcnt = 0;
      else if (fall_e) begin
        if (!mode_tx) begin
          if (lsbn) acc[mcnt] = bin[0]; else acc[7-mcnt] = bin[0];
          mblsb = lsbn;
          if (mcnt == 7) begin rxpush = (rxs != DEPTH); mcnt = 0; end
          else mcnt++;
        end else if (mcnt != 0 || txs != 0) begin
          if (mcnt == 0) begin mtxb = txq[0]; txpop = 1; end
          mout = lsbn ? mtxb[mcnt] : mtxb[7-mcnt];
          mblsb = lsbn;
          mcnt = (mcnt == 7) ? 0 : mcnt + 1;
        end
      end
      if (rx_ready && rxs != 0) void'(rxq.pop_front());
      if (rxpush) rxq.push_back(acc);
      if (txpop) void'(txq.pop_front());
      if (tx_valid && txs != DEPTH) txq.push_back(tx_data);
      if (order_msb_set) mlsb = 0; else if (order_lsb_set) mlsb = 1;
      mdir = mode_tx;
      ms3 = ms2; ms2 = ms1; ms1 = sck_in;
      md2 = md1; md1 = sd_in;
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(int'(xfer_req) == mreq, mdir ? "R8 model xfer_req" : "R5 model xfer_req", xfer_req, mreq);
      chk(rx_valid == (rxq.size() != 0), "R4 model rx_valid", rx_valid, rxq.size() != 0);
      if (rx_valid && rxq.size() != 0) chk(rx_data == rxq[0], "R4 model rx_data", rx_data, rxq[0]);
      chk(tx_ready == (txq.size() != DEPTH), "R6 model tx_ready", tx_ready, txq.size() != DEPTH);
      chk(int'(sd_out) == mout, "R7 model sd_out", sd_out, mout);
      chk(int'(sd_out_en) == mdir, "R11 model sd_out_en", sd_out_en, mdir);
    end
  end

  // host-side helpers
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input bit lsb, input int from, input int to);
    for (int k = from; k <= to; k++) begin
      @(negedge clk);
      sd_in = lsb ? b[k] : b[7-k];
      wait_cyc(HALF);
      sck_in = 1'b0;
      wait_cyc(HALF);
      sck_in = 1'b1;
    end
    wait_cyc(HALF);
  endtask

  task automatic recv_byte(input bit lsb, output logic [7:0] b);
    b = 8'h00;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      sck_in = 1'b0;
      wait_cyc(HALF);
      sck_in = 1'b1;
      if (lsb) b[k] = sd_out; else b[7-k] = sd_out;
      wait_cyc(HALF);
    end
  endtask

  task automatic pulse_order(input bit lsb_p, input bit msb_p);
    @(negedge clk);
    order_lsb_set = lsb_p; order_msb_set = msb_p;
    @(negedge clk);
    order_lsb_set = 1'b0; order_msb_set = 1'b0;
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rx_valid == 1'b1, tag, rx_valid, 1);
    chk(rx_data == exp, tag, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  initial begin
    logic [7:0] got;
    wait_cyc(3);
    // R1 reset state
    chk(xfer_req == 1'b0, "R1 xfer_req in reset", xfer_req, 0);
    chk(rx_valid == 1'b0, "R1 rx_valid in reset", rx_valid, 0);
    chk(sd_out == 1'b0, "R1 sd_out in reset", sd_out, 0);
    chk(sd_out_en == 1'b0, "R1 sd_out_en in reset", sd_out_en, 0);
    chk(tx_ready == 1'b1, "R1 tx_ready in reset", tx_ready, 1);
    rst = 1'b0;
    wait_cyc(4);
    chk(xfer_req == 1'b1, "R5 request with empty rx FIFO", xfer_req, 1);

    // R2 MSB-first receive
    send_bits(8'hA5, 1'b0, 0, 7);
    pop_expect(8'hA5, "R2 msb-first byte");
    send_bits(8'h1E, 1'b0, 0, 7);
    pop_expect(8'h1E, "R2 msb-first second byte");

    // R3 LSB-first and restore; both pulses pick MSB
    pulse_order(1'b1, 1'b0);
    send_bits(8'h3C, 1'b1, 0, 7);
    pop_expect(8'h3C, "R3 lsb-first byte");
    send_bits(8'h71, 1'b1, 0, 7);
    pop_expect(8'h71, "R3 lsb-first second byte");
    pulse_order(1'b1, 1'b1);
    send_bits(8'h1E, 1'b0, 0, 7);
    pop_expect(8'h1E, "R3 both pulses select msb");

    // R10 mid-byte order change applies next byte
    send_bits(8'hC6, 1'b0, 0, 3);
    pulse_order(1'b1, 1'b0);
    send_bits(8'hC6, 1'b0, 4, 7);
    pop_expect(8'hC6, "R10 mid-byte change ignored");
    send_bits(8'h59, 1'b1, 0, 7);
    pop_expect(8'h59, "R10 change active next byte");
    pulse_order(1'b0, 1'b1);

    // R9 direction change discards partial byte
    send_bits(8'hFF, 1'b0, 0, 2);
    @(negedge clk); mode_tx = 1'b1;
    wait_cyc(2);
    mode_tx = 1'b0;
    wait_cyc(4);
    chk(rx_valid == 1'b0, "R9 partial byte discarded", rx_valid, 0);
    send_bits(8'h42, 1'b0, 0, 7);
    pop_expect(8'h42, "R9 realigned byte");

    // R5 full FIFO drops request and overflow byte; R4 ordering
    for (int i = 0; i < DEPTH; i++) send_bits(8'h10 + 8'(i), 1'b0, 0, 7);
    wait_cyc(2);
    chk(xfer_req == 1'b0, "R5 request low when rx FIFO full", xfer_req, 0);
    send_bits(8'hEE, 1'b0, 0, 7);
    for (int i = 0; i < DEPTH; i++) pop_expect(8'h10 + 8'(i), "R4 fifo order");
    wait_cyc(1);
    chk(rx_valid == 1'b0, "R5 overflow byte dropped", rx_valid, 0);
    wait_cyc(1);
    chk(xfer_req == 1'b1, "R5 request back after drain", xfer_req, 1);

    // transmit mode
    @(negedge clk); mode_tx = 1'b1;
    wait_cyc(3);
    chk(sd_out_en == 1'b1, "R11 enable in transmit mode", sd_out_en, 1);
    chk(xfer_req == 1'b0, "R8 no request with empty tx FIFO", xfer_req, 0);
    push_tx(8'hB4);
    wait_cyc(1);
    chk(xfer_req == 1'b1, "R8 request with queued byte", xfer_req, 1);
    push_tx(8'hD2); push_tx(8'h0F); push_tx(8'h77);
    wait_cyc(1);
    chk(tx_ready == 1'b0, "R6 tx_ready low when full", tx_ready, 0);
    push_tx(8'h99);
    recv_byte(1'b0, got);
    chk(got == 8'hB4, "R7 msb-first transmit", got, 8'hB4);
    wait_cyc(1);
    chk(tx_ready == 1'b1, "R6 tx_ready after pop", tx_ready, 1);
    pulse_order(1'b1, 1'b0);
    recv_byte(1'b1, got);
    chk(got == 8'hD2, "R7 lsb-first transmit", got, 8'hD2);
    pulse_order(1'b0, 1'b1);
    recv_byte(1'b0, got);
    chk(got == 8'h0F, "R7 third byte", got, 8'h0F);
    recv_byte(1'b0, got);
    chk(got == 8'h77, "R6 full-FIFO offer not queued", got, 8'h77);
    wait_cyc(3);
    chk(xfer_req == 1'b0, "R8 request low after last byte", xfer_req, 0);
    got[0] = sd_out;
    @(negedge clk); sck_in = 1'b0;
    wait_cyc(HALF);
    sck_in = 1'b1;
    wait_cyc(HALF);
    chk(sd_out == got[0], "R7 empty FIFO holds sd_out", sd_out, got[0]);

    @(negedge clk); mode_tx = 1'b0;
    wait_cyc(3);
    chk(sd_out_en == 1'b0, "R11 enable off in receive mode", sd_out_en, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule